// File: doc/BRIEF.md
# Cascadable Up/Down Count Stage

This block is a small binary counter stage with two separate count inputs. One input counts up and the other counts down. Both inputs idle high. A count event is a low-going pulse, and the count moves when the pulse ends, provided the other input stayed high across that edge. A synchronous clear and an active-low parallel load set the count directly.

Each stage has two active-low flags. The carry flag copies an up pulse while the stage holds its maximum value. The borrow flag copies a down pulse while the stage holds zero. Wiring the carry flag to the next stage's up input and the borrow flag to its down input builds wider counters from identical stages. A common use is a position tally fed with up or down pulses from a direction decoder.

Both count inputs are brought into the system clock domain through a synchronizer chain and edge-detected there. Clear and load are sampled directly on the clock.

Top module: `bidir_count_stage`

## Requirements
- R1: The end (rising edge) of a low pulse on `cnt_up`, with `cnt_dn` high both before and after that edge, increments `q` by one, modulo 2^WIDTH. The result is visible no later than SYNC_STAGES+1 clock edges after the edge.
- R2: The end of a low pulse on `cnt_dn`, with `cnt_up` high both before and after that edge, decrements `q` by one, modulo 2^WIDTH.
- R3: A pulse on one count input while the other count input is held low leaves `q` unchanged.
- R4: Low pulses that start and end in the same clock cycle on both count inputs leave `q` unchanged.
- R5: `clear` = 1 sets `q` to 0 at the next clock edge. It overrides both load and counting.
- R6: `load_n` = 0 with `clear` = 0 copies `data` into `q` at the next clock edge. It overrides counting.
- R7: `carry_n` is 0 exactly while `q` is all ones, the synchronized `cnt_up` is low and the synchronized `cnt_dn` is high. Otherwise it is 1.
- R8: `borrow_n` is 0 exactly while `q` is zero, the synchronized `cnt_dn` is low and the synchronized `cnt_up` is high. Otherwise it is 1.
- R9: Four stages, chained carry-to-up and borrow-to-down, form a 16-bit counter. It wraps from 0xFFFF to 0x0000 on an up pulse and from 0x0000 to 0xFFFF on a down pulse.
- R10: While `rst` is high, `q` becomes 0 and both count inputs are taken as idle high, so `carry_n` = 1 and `borrow_n` = 1.
- R11: Up pulses combined with a reload of 3 each time the count reaches 11 make the counter step through the range 3 to 11 and back to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_up | input | 1 | Up-count pulse input, idle high |
| cnt_dn | input | 1 | Down-count pulse input, idle high |
| clear | input | 1 | Synchronous clear, active high |
| load_n | input | 1 | Parallel load, active low |
| data | input | WIDTH | Value taken on load |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry to the next stage's up input |
| borrow_n | output | 1 | Active-low borrow to the next stage's down input |

## Verification
The hardest case to reach is a full wrap of a four-stage chain. There, each stage's pulse must pass through the next stage's synchronizer before that stage moves. The stimulus loads 0xFFFF or 0x0000 into the chain and then sends a single pulse of several cycles into the lowest stage. It waits long enough for the ripple to reach the top stage before it reads the 16-bit value. The flag states exist only while a pulse is held low, so the bench holds an input low and checks the flags before it releases the input. In the same way, it reads the count during a blocked pulse before releasing the opposite input.

// File: rtl/cnt_casc_pkg.sv
package cnt_casc_pkg;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4
  } cnt_op_e;

  // Priority: clear, then load, then a single qualified count step
  function automatic cnt_op_e pick_op(input logic clr, input logic ld_n,
                                      input logic inc, input logic dec);
    if (clr)            return OP_CLEAR;
    else if (!ld_n)     return OP_LOAD;
    else if (inc && !dec) return OP_INC;
    else if (dec && !inc) return OP_DEC;
    else                return OP_HOLD;
  endfunction

endpackage

// File: rtl/pulse_sync.sv
module pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic lvl,
  output logic lvl_prev
);

  logic [STAGES-1:0] chain;
  logic              prev_r;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= raw;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], raw};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_r <= 1'b1;
    else     prev_r <= chain[STAGES-1];
  end

  assign lvl      = chain[STAGES-1];
  assign lvl_prev = prev_r;

endmodule

// File: rtl/count_core.sv
module count_core
  import cnt_casc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else begin
      unique case (op)
        OP_CLEAR: q_r <= '0;
        OP_LOAD:  q_r <= data;
        OP_INC:   q_r <= q_r + ONE;
        OP_DEC:   q_r <= q_r - ONE;
        default:  q_r <= q_r;
      endcase
    end
  end

  assign q = q_r;

  // R1
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INC) |=> (q_r == $past(q_r) + ONE));

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DEC) |=> (q_r == $past(q_r) - ONE));

  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (q_r == $past(data)));

  // R10
  reset_zero_chk: assert property (@(posedge clk)
    $past(rst) |-> (q_r == '0));

endmodule

// File: rtl/cascade_flags.sv
module cascade_flags #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] q,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);

  logic at_top;
  logic at_floor;

  assign at_top   = &q;
  assign at_floor = ~|q;

  // Only register outputs feed these gates, so the flags follow the
  // synchronized pulse without adding a cycle per chained stage
  assign carry_n  = ~(at_top   & ~up_lvl & dn_lvl);
  assign borrow_n = ~(at_floor & ~dn_lvl & up_lvl);

  // R7
  carry_at_max_chk: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (q == {WIDTH{1'b1}}));

  // R8
  borrow_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (q == '0));

  // R7 R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (carry_n || borrow_n));

endmodule

// File: rtl/bidir_count_stage.sv
module bidir_count_stage
  import cnt_casc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] q,
  output logic             carry_n,
  output logic             borrow_n
);

  logic    up_lvl, up_prev, dn_lvl, dn_prev;
  logic    up_rise, dn_rise;
  logic    step_up, step_dn;
  cnt_op_e op;

  pulse_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst(rst), .raw(cnt_up), .lvl(up_lvl), .lvl_prev(up_prev)
  );

  pulse_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .rst(rst), .raw(cnt_dn), .lvl(dn_lvl), .lvl_prev(dn_prev)
  );

  assign up_rise = up_lvl & ~up_prev;
  assign dn_rise = dn_lvl & ~dn_prev;

  // The opposite input must be high on both sides of the edge
  assign step_up = up_rise & dn_lvl & dn_prev;
  assign step_dn = dn_rise & up_lvl & up_prev;

  assign op = pick_op(clear, load_n, step_up, step_dn);

  count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .op(op), .data(data), .q(q)
  );

  cascade_flags #(.WIDTH(WIDTH)) u_flags (
    .clk(clk), .rst(rst), .q(q), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (q == '0));

  // R3
  up_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (up_rise && !dn_lvl && !clear && load_n) |=> $stable(q));

  // R3
  dn_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_rise && !up_lvl && !clear && load_n) |=> $stable(q));

  // R4
  both_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (up_rise && dn_rise && !clear && load_n) |=> $stable(q));

  // R1 R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!up_rise && !dn_rise && !clear && load_n) |=> $stable(q));

endmodule

// File: tb/sim_bidir_count_stage.sv
module sim_bidir_count_stage;

  localparam int W      = 4;
  localparam int TOTAL  = 4 * W;
  localparam int SETTLE = 24;

  // Vector op codes
  localparam logic [2:0] V_CLR  = 3'd0;
  localparam logic [2:0] V_LOAD = 3'd1;
  localparam logic [2:0] V_UP   = 3'd2;
  localparam logic [2:0] V_DN   = 3'd3;
  localparam logic [2:0] V_BOTH = 3'd4;

  localparam int NV = 14;
  // {op, data, expected 16-bit count}
  localparam logic [34:0] VEC [NV] = '{
    {V_LOAD, 16'h1234, 16'h1234},
    {V_UP,   16'h0000, 16'h1235},
    {V_UP,   16'h0000, 16'h1236},
    {V_DN,   16'h0000, 16'h1235},
    {V_LOAD, 16'h00FF, 16'h00FF},
    {V_UP,   16'h0000, 16'h0100},
    {V_DN,   16'h0000, 16'h00FF},
    {V_BOTH, 16'h0000, 16'h00FF},
    {V_LOAD, 16'h0A5F, 16'h0A5F},
    {V_BOTH, 16'h0000, 16'h0A5F},
    {V_DN,   16'h0000, 16'h0A5E},
    {V_CLR,  16'h0000, 16'h0000},
    {V_DN,   16'h0000, 16'hFFFF},
    {V_UP,   16'h0000, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_in = 1'b1;
  logic dn_in = 1'b1;
  logic clr = 1'b0;
  logic ld_n = 1'b1;
  logic [TOTAL-1:0] din = '0;

  logic [W-1:0] q0, q1, q2, q3;
  logic c0, c1, c2, c3, b0, b1, b2, b3;
  logic [TOTAL-1:0] qall;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign qall = {q3, q2, q1, q0};

  bidir_count_stage #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .cnt_up(up_in), .cnt_dn(dn_in), .clear(clr),
    .load_n(ld_n), .data(din[3:0]), .q(q0), .carry_n(c0), .borrow_n(b0));
  bidir_count_stage #(.WIDTH(W)) u1 (
    .clk(clk), .rst(rst), .cnt_up(c0), .cnt_dn(b0), .clear(clr),
    .load_n(ld_n), .data(din[7:4]), .q(q1), .carry_n(c1), .borrow_n(b1));
  bidir_count_stage #(.WIDTH(W)) u2 (
    .clk(clk), .rst(rst), .cnt_up(c1), .cnt_dn(b1), .clear(clr),
    .load_n(ld_n), .data(din[11:8]), .q(q2), .carry_n(c2), .borrow_n(b2));
  bidir_count_stage #(.WIDTH(W)) u3 (
    .clk(clk), .rst(rst), .cnt_up(c2), .cnt_dn(b2), .clear(clr),
    .load_n(ld_n), .data(din[15:12]), .q(q3), .carry_n(c3), .borrow_n(b3));

  task automatic report();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [TOTAL-1:0] act,
                     input logic [TOTAL-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    wait_n(2);
  endtask

  task automatic do_load(input logic [TOTAL-1:0] v);
    @(negedge clk); din = v; ld_n = 1'b0;
    @(negedge clk); ld_n = 1'b1;
    wait_n(2);
  endtask

  // Low pulse of three cycles on the selected inputs, then settle
  task automatic pulse(input bit on_up, input bit on_dn);
    @(negedge clk);
    if (on_up) up_in = 1'b0;
    if (on_dn) dn_in = 1'b0;
    wait_n(3);
    up_in = 1'b1;
    dn_in = 1'b1;
    wait_n(SETTLE);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  initial begin
    logic [TOTAL-1:0] exp;
    wait_n(4);
    // R10 reset state
    chk("R10 q", qall, '0);
    chk("R10 carry_n", {15'd0, c0}, 16'd1);
    chk("R10 borrow_n", {15'd0, b0}, 16'd1);
    @(negedge clk); rst = 1'b0;
    wait_n(4);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      case (VEC[k][34:32])
        V_CLR:  do_clear();
        V_LOAD: do_load(VEC[k][31:16]);
        V_UP:   pulse(1'b1, 1'b0);
        V_DN:   pulse(1'b0, 1'b1);
        default: pulse(1'b1, 1'b1);
      endcase
      case (VEC[k][34:32])
        V_CLR:  chk("R5 clear", qall, VEC[k][15:0]);
        V_LOAD: chk("R6 load", qall, VEC[k][15:0]);
        V_UP:   chk("R1 up step", qall, VEC[k][15:0]);
        V_DN:   chk("R2 down step", qall, VEC[k][15:0]);
        default: chk("R4 both pulses", qall, VEC[k][15:0]);
      endcase
    end

    // R9 full wrap in both directions
    do_load(16'hFFFF);
    pulse(1'b1, 1'b0);
    chk("R9 wrap FFFF->0000", qall, 16'h0000);
    pulse(1'b0, 1'b1);
    chk("R9 wrap 0000->FFFF", qall, 16'hFFFF);

    // R7 carry while up is held low at the top of a nibble
    do_load(16'h004F);
    @(negedge clk); up_in = 1'b0;
    wait_n(5);
    chk("R7 carry_n low", {15'd0, c0}, 16'd0);
    chk("R7 next carry_n high", {15'd0, c1}, 16'd1);
    up_in = 1'b1;
    wait_n(SETTLE);
    chk("R7 carry_n released", {15'd0, c0}, 16'd1);
    chk("R7 count", qall, 16'h0050);

    // R8 borrow while down is held low at zero in the low nibble
    @(negedge clk); dn_in = 1'b0;
    wait_n(5);
    chk("R8 borrow_n low", {15'd0, b0}, 16'd0);
    dn_in = 1'b1;
    wait_n(SETTLE);
    chk("R8 borrow_n released", {15'd0, b0}, 16'd1);
    chk("R8 count", qall, 16'h004F);

    // R3 up pulse while down is held low: no change before down releases
    do_load(16'h0025);
    @(negedge clk); dn_in = 1'b0;
    wait_n(4);
    pulse(1'b1, 1'b0);
    dn_in = 1'b0;
    wait_n(4);
    chk("R3 up blocked", qall, 16'h0025);
    dn_in = 1'b1;
    wait_n(SETTLE);
    chk("R3 down release steps", qall, 16'h0024);

    // R5 clear overrides a simultaneous load
    do_load(16'h0777);
    @(negedge clk); clr = 1'b1; ld_n = 1'b0; din = 16'h0999;
    @(negedge clk); clr = 1'b0; ld_n = 1'b1;
    wait_n(2);
    chk("R5 clear over load", qall, 16'h0000);

    // R6 load held through an up pulse wins over counting
    @(negedge clk); din = 16'h0123; ld_n = 1'b0;
    up_in = 1'b0;
    wait_n(3);
    up_in = 1'b1;
    wait_n(6);
    ld_n = 1'b1;
    wait_n(SETTLE);
    chk("R6 load over count", qall, 16'h0123);

    // R11 range 3..11 with reload
    do_load(16'h0003);
    exp = 16'h0003;
    for (int s = 0; s < 10; s++) begin
      if (exp == 16'd11) begin
        do_load(16'h0003);
        exp = 16'h0003;
      end else begin
        pulse(1'b1, 1'b0);
        exp = exp + 16'd1;
      end
      chk("R11 range sequence", qall, exp);
    end

    done = 1'b1;
    report();
  end

endmodule